// File: doc/BRIEF.md
# Configuration Change Protection Unit

This block gates writes to protected control registers and protected program-memory operations (self-programming stores and program-memory loads) inside a small CPU subsystem. Software unlocks one class of operation by writing a signature byte to an unlock register. A valid signature opens a short window for that class. The window is counted in retired instructions. While it is open, one protected operation of that class may go through, and the block holds off interrupt acceptance.

The unlock register has a write port. Its readback shows which class is open. The CPU's retire strobe ages the window. Request strobes from the protected-register write path and from the program-memory path are passed on only while their class is enabled. The interrupt controller sees a single inhibit line that is high whenever either class is open.

Top module: `cfg_guard`

## Requirements
- R1: After reset both class enables are low, the readback value is 0x00 and the interrupt-inhibit output is low. At most one class is ever enabled at a time.
- R2: Writing 0xD8 to the unlock register enables the I/O-register class from the next clock cycle. Readback bit 0 is then 1.
- R3: Writing 0x9D to the unlock register enables the program-memory class from the next clock cycle. Readback bit 1 is then 1.
- R4: An open window survives three retire strobes. It closes in the cycle after the fourth retire strobe. Cycles without a retire strobe do not age it.
- R5: A write to the unlock register of any value other than 0xD8 or 0x9D leaves both enables unchanged. It also leaves the remaining window length unchanged.
- R6: The interrupt-inhibit output is high in exactly the cycles in which either class enable is high.
- R7: Readback bits 7 to 2 always read as zero.
- R8: A protected I/O-register write request passes (iow_pass) only while the I/O class is enabled. A passed request closes the I/O window in the next cycle.
- R9: A protected program-memory request passes (pgm_pass) only while the program-memory class is enabled. A passed request closes that window in the next cycle.
- R10: A signature write while a window is open reloads a full four-retire window for the signature's class and closes the other class. A signature write takes precedence over a retire strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ulk_wr | input | 1 | Unlock register write strobe |
| ulk_wdata | input | 8 | Unlock register write data |
| ulk_rdata | output | 8 | Unlock register readback (bit 1 program-memory class, bit 0 I/O class) |
| instr_retire | input | 1 | One pulse per retired instruction |
| iow_req | input | 1 | Protected I/O-register write request |
| pgm_req | input | 1 | Protected program-memory operation request |
| iow_pass | output | 1 | Protected I/O write allowed |
| pgm_pass | output | 1 | Protected program-memory operation allowed |
| io_en | output | 1 | I/O-register class enabled |
| pgm_en | output | 1 | Program-memory class enabled |
| irq_hold | output | 1 | Interrupt acceptance inhibit |

## Verification
The bench sends a window through long gaps without retire strobes. A design that counts clock cycles instead of retirements would close early. It writes a stray byte into the middle of an open window, which catches a design that reloads or clears the counter on every write. It also switches class mid-window and writes a signature in the same cycle as a retire. Either mistake shows up, as two enables high at once or as a window one retire short. Protected requests are also issued while their class is closed and again while it is open. A leaky gate, or a window that stays open after its one use, then shows on the pass and enable outputs.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
   localparam int unsigned NUM_CLASS = 2;
   localparam int unsigned IDX_IOREG = 0;
   localparam int unsigned IDX_PGM   = 1;

   function automatic int unsigned cnt_width(input int unsigned len);
      return $clog2(len + 1);
   endfunction
endpackage

// File: rtl/cg_sig_decode.sv
`timescale 1ns/1ps
module cg_sig_decode #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_CLASS = 2,
   parameter logic [NUM_CLASS*DATA_W-1:0] SIGS = '0
) (
   input  logic                 wr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_CLASS-1:0] hit
);
   generate
      for (genvar gi = 0; gi < NUM_CLASS; gi++) begin : g_cmp
         assign hit[gi] = wr && (wdata == SIGS[gi*DATA_W +: DATA_W]);
      end
   endgenerate
endmodule

// File: rtl/cg_window.sv
`timescale 1ns/1ps
module cg_window #(
   parameter int unsigned WIN_LEN = 4,
   localparam int unsigned CNT_W  = $clog2(WIN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             kill,
   input  logic             use_i,
   input  logic             retire,
   output logic             en,
   output logic [CNT_W-1:0] remain
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN_LEN);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         remain <= '0;
      end else if (load) begin
         en     <= 1'b1;
         remain <= FULL;
      end else if (kill || (en && use_i)) begin
         en     <= 1'b0;
         remain <= '0;
      end else if (en && retire) begin
         remain <= remain - ONE;
         if (remain == ONE) en <= 1'b0;
      end
   end

   a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (en && remain == FULL));
   a_r4_last_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (en && remain == ONE && retire && !load) |=> !en);
   a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !kill && !use_i && !retire) |=> ($stable(en) && $stable(remain)));
   a_r8_use_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (en && use_i && !load) |=> !en);
endmodule

// File: rtl/cg_readback.sv
`timescale 1ns/1ps
module cg_readback #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_CLASS = 2
) (
   input  logic [NUM_CLASS-1:0] en,
   output logic [DATA_W-1:0]    rdata,
   output logic                 irq_hold
);
   always_comb begin
      rdata                = '0;
      rdata[NUM_CLASS-1:0] = en;
   end
   assign irq_hold = |en;

   always_comb begin
      a_r6_inhibit: assert (irq_hold == (en != '0));
      a_r7_upper_zero: assert (rdata[DATA_W-1:NUM_CLASS] == '0);
   end
endmodule

// File: rtl/cfg_guard.sv
`timescale 1ns/1ps
module cfg_guard #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned WIN_LEN = 4,
   parameter logic [7:0]  SIG_IO  = 8'hD8,
   parameter logic [7:0]  SIG_PGM = 8'h9D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ulk_wr,
   input  logic [DATA_W-1:0] ulk_wdata,
   output logic [DATA_W-1:0] ulk_rdata,
   input  logic              instr_retire,
   input  logic              iow_req,
   input  logic              pgm_req,
   output logic              iow_pass,
   output logic              pgm_pass,
   output logic              io_en,
   output logic              pgm_en,
   output logic              irq_hold
);
   import cg_pkg::*;
   localparam int unsigned NC = NUM_CLASS;
   localparam logic [NC*DATA_W-1:0] SIGS =
      {DATA_W'(SIG_PGM), DATA_W'(SIG_IO)};

   generate
      if (DATA_W < NC) begin : g_bad_width
         $error("DATA_W too small for readback bits");
      end
      if (WIN_LEN < 1) begin : g_bad_len
         $error("WIN_LEN must be at least one");
      end
      if (SIG_IO == SIG_PGM) begin : g_bad_sig
         $error("signatures must differ");
      end
   endgenerate

   logic [NC-1:0] hit;
   logic [NC-1:0] use_v;
   logic [NC-1:0] en_v;

   assign use_v[IDX_IOREG] = iow_req;
   assign use_v[IDX_PGM]   = pgm_req;

   cg_sig_decode #(.DATA_W(DATA_W), .NUM_CLASS(NC), .SIGS(SIGS)) u_dec (
      .wr(ulk_wr), .wdata(ulk_wdata), .hit(hit)
   );

   generate
      for (genvar gc = 0; gc < NC; gc++) begin : g_cls
         logic [$clog2(WIN_LEN+1)-1:0] remain;
         cg_window #(.WIN_LEN(WIN_LEN)) u_win (
            .clk(clk), .rst_n(rst_n),
            .load(hit[gc]),
            .kill((|hit) && !hit[gc]),
            .use_i(use_v[gc]),
            .retire(instr_retire),
            .en(en_v[gc]),
            .remain(remain)
         );
      end
   endgenerate

   cg_readback #(.DATA_W(DATA_W), .NUM_CLASS(NC)) u_rb (
      .en(en_v), .rdata(ulk_rdata), .irq_hold(irq_hold)
   );

   assign io_en    = en_v[IDX_IOREG];
   assign pgm_en   = en_v[IDX_PGM];
   assign iow_pass = iow_req && io_en;
   assign pgm_pass = pgm_req && pgm_en;

   a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({io_en, pgm_en}));
   a_r2_io_open: assert property (@(posedge clk) disable iff (!rst_n)
      (ulk_wr && ulk_wdata == DATA_W'(SIG_IO)) |=> (io_en && !pgm_en));
   a_r3_pgm_open: assert property (@(posedge clk) disable iff (!rst_n)
      (ulk_wr && ulk_wdata == DATA_W'(SIG_PGM)) |=> (pgm_en && !io_en));
   a_r8_io_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (iow_req && !ulk_rdata[0]) |-> !iow_pass);
   a_r9_pgm_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_req && !ulk_rdata[1]) |-> !pgm_pass);
endmodule

// File: tb/cfg_guard_tb.sv
`timescale 1ns/1ps
module cfg_guard_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ulk_wr = 1'b0;
   logic [7:0] ulk_wdata = '0;
   logic [7:0] ulk_rdata;
   logic instr_retire = 1'b0;
   logic iow_req = 1'b0;
   logic pgm_req = 1'b0;
   logic iow_pass, pgm_pass, io_en, pgm_en, irq_hold;

   always #2.5 clk = ~clk;

   cfg_guard u_dut (
      .clk(clk), .rst_n(rst_n), .ulk_wr(ulk_wr), .ulk_wdata(ulk_wdata),
      .ulk_rdata(ulk_rdata), .instr_retire(instr_retire), .iow_req(iow_req),
      .pgm_req(pgm_req), .iow_pass(iow_pass), .pgm_pass(pgm_pass),
      .io_en(io_en), .pgm_en(pgm_en), .irq_hold(irq_hold)
   );

   typedef struct {
      logic [7:0] rdata;
      logic       irq;
      logic       io;
      logic       pgm;
      string      tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic       m_en [2];
   int         m_cnt[2];
   logic [7:0] m_sig[2];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops expected state after each edge
   always @(posedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         #1;
         e = q.pop_front();
         chk({e.tag, " R7 rdata"}, ulk_rdata, e.rdata);
         chk({e.tag, " R6 irq_hold"}, {7'd0, irq_hold}, {7'd0, e.irq});
         chk({e.tag, " io_en"}, {7'd0, io_en}, {7'd0, e.io});
         chk({e.tag, " pgm_en"}, {7'd0, pgm_en}, {7'd0, e.pgm});
      end
   end

   // driver: one cycle of stimulus, model update, push expectation
   task automatic step(input logic wr, input logic [7:0] d, input logic ret,
                       input logic iw, input logic pg, input string tag);
      logic usev[2];
      exp_t e;
      @(negedge clk);
      ulk_wr = wr; ulk_wdata = d; instr_retire = ret; iow_req = iw; pgm_req = pg;
      #0.5;
      chk({tag, " R8 iow_pass"}, {7'd0, iow_pass}, {7'd0, iw & m_en[0]});
      chk({tag, " R9 pgm_pass"}, {7'd0, pgm_pass}, {7'd0, pg & m_en[1]});
      usev[0] = iw; usev[1] = pg;
      for (int c = 0; c < 2; c++) begin
         if (wr && d == m_sig[c]) begin
            m_en[c] = 1'b1; m_cnt[c] = 4;
         end else if (wr && d == m_sig[1-c]) begin
            m_en[c] = 1'b0; m_cnt[c] = 0;
         end else if (m_en[c] && usev[c]) begin
            m_en[c] = 1'b0; m_cnt[c] = 0;
         end else if (m_en[c] && ret) begin
            m_cnt[c] = m_cnt[c] - 1;
            if (m_cnt[c] == 0) m_en[c] = 1'b0;
         end
      end
      e.rdata = {6'd0, m_en[1], m_en[0]};
      e.irq   = m_en[0] | m_en[1];
      e.io    = m_en[0];
      e.pgm   = m_en[1];
      e.tag   = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, tag);
   endtask

   initial begin
      #100000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      m_en[0] = 0; m_en[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_sig[0] = 8'hD8; m_sig[1] = 8'h9D;
      #12;
      chk("R1 reset rdata", ulk_rdata, 8'h00);
      chk("R1 reset irq", {7'd0, irq_hold}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      idle(1, "R1 idle");
      // R2 + R4: open I/O class, retires with gaps
      step(1, 8'hD8, 0, 0, 0, "R2 open io");
      step(0, 8'h00, 1, 0, 0, "R4 retire1");
      idle(3, "R4 gap no retire");
      step(0, 8'h00, 1, 0, 0, "R4 retire2");
      step(0, 8'h00, 1, 0, 0, "R4 retire3");
      idle(2, "R4 still open");
      step(0, 8'h00, 1, 0, 0, "R4 retire4 closes");
      idle(1, "R4 closed");
      // R3 + R5: stray writes mid-window
      step(1, 8'h9D, 0, 0, 0, "R3 open pgm");
      step(0, 8'h00, 1, 0, 0, "R5 retire1");
      step(1, 8'h55, 0, 0, 0, "R5 stray write");
      step(1, 8'hFF, 1, 0, 0, "R5 stray with retire");
      step(1, 8'h00, 0, 0, 0, "R5 stray zero");
      step(0, 8'h00, 1, 0, 0, "R5 retire3");
      step(0, 8'h00, 1, 0, 0, "R5 retire4 closes");
      step(1, 8'h12, 0, 0, 0, "R5 stray when closed");
      // R8: blocked then passed
      step(0, 8'h00, 0, 1, 0, "R8 blocked");
      step(1, 8'hD8, 0, 0, 0, "R8 open io");
      step(0, 8'h00, 0, 0, 1, "R9 pgm blocked in io window");
      step(0, 8'h00, 0, 1, 0, "R8 write passes");
      step(0, 8'h00, 0, 1, 0, "R8 second write blocked");
      // R9
      step(1, 8'h9D, 0, 0, 0, "R9 open pgm");
      step(0, 8'h00, 1, 0, 1, "R9 op passes");
      step(0, 8'h00, 0, 0, 1, "R9 second op blocked");
      // R10: class switch and reload
      step(1, 8'hD8, 0, 0, 0, "R10 open io");
      step(0, 8'h00, 1, 0, 0, "R10 retire");
      step(1, 8'h9D, 0, 0, 0, "R10 switch to pgm");
      step(0, 8'h00, 1, 0, 0, "R10 retire a");
      step(0, 8'h00, 1, 0, 0, "R10 retire b");
      step(1, 8'h9D, 1, 0, 0, "R10 reload with retire");
      step(0, 8'h00, 1, 0, 0, "R10 r1");
      step(0, 8'h00, 1, 0, 0, "R10 r2");
      step(0, 8'h00, 1, 0, 0, "R10 r3");
      step(0, 8'h00, 1, 0, 0, "R10 r4 closes");
      step(1, 8'hD8, 1, 0, 0, "R10 io with retire");
      step(1, 8'h9D, 0, 0, 0, "R10 back to pgm");
      idle(3, "R6 tail");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule